// File: doc/BRIEF.md
# GPIO Pin Controller with SD Card Routing

This block is a register-mapped controller for 54 general-purpose pins, driven by a simple single-cycle register bus with 32-bit data. Software gives each pin a 3-bit function code, stored ten pins per function word. It changes pin levels through separate set and clear registers, where each written 1 bit acts and each 0 bit is ignored. It reads the stored levels back from two read-only registers. A pin drives its stored level onto `pin_out` only while its function code marks it as an output.

The block also owns a sticky route select for a shared SD card, `sd_route`, which picks one of two host controllers. The select moves only when the six card pins 48 to 53 all carry the same routing function code. A mixed set of codes leaves the previous route in place. A range of placeholder offsets reads as zero and accepts writes without effect. Any other offset is refused: it reads zero, changes nothing, and raises a one-cycle error pulse.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every function code and level bit is 0, `pin_out` is all 0, `sd_route` is 0 (controller A), and `rdata` and `bus_err` are 0.
- R2: The function word at offset 4n (n = 0..5) holds pins 10n to 10n+9. Pin 10n+i sits at bits [3i+2:3i]. A write stores the fields, a read returns them, and bits 31:30 always read 0.
- R3: A field that maps to a pin index of 54 or above is dropped on write and reads 0. The word at 0x14 therefore keeps only bits 11:0.
- R4: A write to 0x1C (pins 0-31) or 0x20 (bit k to pin 32+k, bits 31:22 ignored) sets the level bit of each pin whose data bit is 1. Bits written as 0 leave their level bits unchanged. Both offsets read 0.
- R5: A write to 0x28 (pins 0-31) or 0x2C (pins 32-53) clears the level bit of each pin whose data bit is 1. Bits written as 0 leave their level bits unchanged. Both offsets read 0.
- R6: Offset 0x34 returns the levels of pins 0-31. Offset 0x38 returns the levels of pins 32-53 in bits 21:0, with 0 above. Writes to both offsets change nothing.
- R7: Function code 1 means output. `pin_out[p]` equals the level bit of pin p while its code is 1, and is 0 otherwise. Moving a pin off code 1 returns its output to 0.
- R8: Set and clear writes update a pin's level bit whatever its function code. A level stored while the pin is not an output appears on `pin_out` once the pin is made an output.
- R9: `sd_route` becomes 0 (controller A) when pins 48-53 all have code 0. It becomes 1 (controller B) when they all have code 4. Any mixed set of codes keeps the previous route. A new route is visible by the second clock edge after the function-word write.
- R10: The placeholder offsets are 0x40, 0x44, 0x4C, 0x50, 0x58, 0x5C, 0x64, 0x68, 0x70, 0x74, 0x7C, 0x80, 0x88, 0x8C, 0x94, 0x98 and 0x9C. They read 0, ignore writes and raise no error.
- R11: A read or write at any other offset, or at an address with addr[1:0] not 0, reads 0 and changes no state. It sets `bus_err` high for exactly the one cycle after the access.
- R12: `rdata` is loaded at the clock edge where `rd_en` is high and holds while `rd_en` is low. A read and a write to the same offset in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, takes effect at this clock edge |
| rd_en | input | 1 | Read strobe, data appears on `rdata` after this edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to a refused offset |
| pin_out | output | 54 | Driven pin values, level gated by output function |
| sd_route | output | 1 | SD card route, 0 = controller A, 1 = controller B |

## Verification
A wrong function code shows up on `pin_out` in the same cycle its word is written, and it shows up in the read-back one cycle after the next read of that word. A corrupted level bit shows on `pin_out` only for output pins, so the bench reads the level registers back and makes pins outputs after writing their levels. A wrong route state appears on `sd_route` two edges after the deciding write, or stays hidden until the six card pins agree. The bench therefore drives them through mixed, all-zero and all-four patterns. Decode faults show as a nonzero read of a placeholder, an unexpected `bus_err` pulse, or a level or code that changed after a refused write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS    = 54;
    localparam int DW       = 32;
    localparam int AW       = 12;
    localparam int FW       = 3;
    localparam int PER_REG  = 10;
    localparam int NFSEL    = (NPINS + PER_REG - 1) / PER_REG;
    localparam int NLW      = (NPINS + DW - 1) / DW;
    localparam int IW       = $clog2((NFSEL > NLW) ? NFSEL : NLW);
    localparam int SELW     = PER_REG * FW;

    localparam int SD_FIRST = 48;
    localparam int SD_COUNT = 6;

    localparam int OFS_FSEL    = 'h000;
    localparam int OFS_SET     = 'h01C;
    localparam int OFS_CLR     = 'h028;
    localparam int OFS_LEV     = 'h034;
    localparam int OFS_EVT     = 'h040;
    localparam int EVT_GROUPS  = 7;
    localparam int EVT_STRIDE  = 12;
    localparam int OFS_PULL    = 'h094;
    localparam int PULL_WORDS  = 3;

    localparam logic [FW-1:0] FN_OUT  = 3'd1;
    localparam logic [FW-1:0] FN_SD_A = 3'd0;
    localparam logic [FW-1:0] FN_SD_B = 3'd4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_FSEL,
        RK_SET,
        RK_CLR,
        RK_LEV,
        RK_ZERO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [IW-1:0]   idx;
    } dec_t;

    typedef enum logic {
        ROUTE_A = 1'b0,
        ROUTE_B = 1'b1
    } route_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
(
    input  logic [AW-1:0] addr,
    output dec_t          dec
);

    always_comb begin
        dec.kind = RK_NONE;
        dec.idx  = '0;
        if (addr[1:0] == 2'b00) begin
            for (int n = 0; n < NFSEL; n++) begin
                if (addr == AW'(OFS_FSEL + 4 * n)) begin
                    dec.kind = RK_FSEL;
                    dec.idx  = IW'(n);
                end
            end
            for (int w = 0; w < NLW; w++) begin
                if (addr == AW'(OFS_SET + 4 * w)) begin
                    dec.kind = RK_SET;
                    dec.idx  = IW'(w);
                end
                if (addr == AW'(OFS_CLR + 4 * w)) begin
                    dec.kind = RK_CLR;
                    dec.idx  = IW'(w);
                end
                if (addr == AW'(OFS_LEV + 4 * w)) begin
                    dec.kind = RK_LEV;
                    dec.idx  = IW'(w);
                end
            end
            for (int g = 0; g < EVT_GROUPS; g++) begin
                for (int w = 0; w < NLW; w++) begin
                    if (addr == AW'(OFS_EVT + g * EVT_STRIDE + 4 * w)) begin
                        dec.kind = RK_ZERO;
                    end
                end
            end
            for (int k = 0; k < PULL_WORDS; k++) begin
                if (addr == AW'(OFS_PULL + 4 * k)) begin
                    dec.kind = RK_ZERO;
                end
            end
        end
    end

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
    import gpio_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [IW-1:0]                   idx,
    input  logic [SELW-1:0]                 wdata,
    output logic [DW-1:0]                   rd_word,
    output logic [NPINS-1:0]                is_out,
    output logic [SD_COUNT-1:0][FW-1:0]     sd_code
);

    typedef struct packed {
        logic [NPINS-1:0][FW-1:0] code;
    } fsel_st_t;

    fsel_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            for (int p = 0; p < NPINS; p++) begin
                if (idx == IW'(p / PER_REG)) begin
                    s_d.code[p] = wdata[FW * (p % PER_REG) +: FW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (idx == IW'(p / PER_REG)) begin
                rd_word[FW * (p % PER_REG) +: FW] = s_q.code[p];
            end
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign is_out[p] = (s_q.code[p] == FN_OUT);
    end

    for (genvar k = 0; k < SD_COUNT; k++) begin : g_sd
        assign sd_code[k] = s_q.code[SD_FIRST + k];
    end

    // R2: codes only move on a function-word write
    p_fsel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(s_q.code));

endmodule

// File: rtl/gpio_level_bank.sv
module gpio_level_bank
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [IW-1:0]    idx,
    input  logic [DW-1:0]    wdata,
    input  logic [NPINS-1:0] is_out,
    output logic [DW-1:0]    rd_word,
    output logic [NPINS-1:0] pin_out
);

    typedef struct packed {
        logic [NPINS-1:0] lev;
    } lev_st_t;

    lev_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NPINS; p++) begin
            if (idx == IW'(p / DW) && wdata[p % DW]) begin
                if (set_wr) begin
                    s_d.lev[p] = 1'b1;
                end else if (clr_wr) begin
                    s_d.lev[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (idx == IW'(p / DW)) begin
                rd_word[p % DW] = s_q.lev[p];
            end
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int WORD = p / DW;
        localparam int BITP = p % DW;

        assign pin_out[p] = s_q.lev[p] & is_out[p];

        // R4: a one bit on the set word raises the level
        p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_wr && idx == IW'(WORD) && wdata[BITP] |=> s_q.lev[p]);

        // R5: a one bit on the clear word drops the level
        p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr_wr && idx == IW'(WORD) && wdata[BITP] |=> !s_q.lev[p]);

        // R4: zero bits leave the level alone
        p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_wr || clr_wr) && idx == IW'(WORD) && !wdata[BITP]
            |=> $stable(s_q.lev[p]));
    end

endmodule

// File: rtl/gpio_sd_route.sv
module gpio_sd_route
    import gpio_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SD_COUNT-1:0][FW-1:0] sd_code,
    output logic                        route
);

    typedef struct packed {
        route_e sel;
    } route_st_t;

    route_st_t s_d, s_q;
    logic      all_a;
    logic      all_b;

    always_comb begin
        all_a = 1'b1;
        all_b = 1'b1;
        for (int k = 0; k < SD_COUNT; k++) begin
            if (sd_code[k] != FN_SD_A) all_a = 1'b0;
            if (sd_code[k] != FN_SD_B) all_b = 1'b0;
        end
    end

    always_comb begin
        s_d = s_q;
        if (all_a) begin
            s_d.sel = ROUTE_A;
        end else if (all_b) begin
            s_d.sel = ROUTE_B;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sel <= ROUTE_A;
        end else begin
            s_q <= s_d;
        end
    end

    assign route = s_q.sel;

    // R9: unanimous zero codes pick controller A
    p_route_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        all_a |=> route == 1'b0);

    // R9: unanimous code four picks controller B
    p_route_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        all_b |=> route == 1'b1);

    // R9: a mixed pattern keeps the route
    p_route_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !all_a && !all_b |=> $stable(route));

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             bus_err,
    output logic [NPINS-1:0] pin_out,
    output logic             sd_route
);

    localparam int LAST_BITS = (NPINS - (NFSEL - 1) * PER_REG) * FW;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } bus_st_t;

    dec_t                        dec;
    logic                        fsel_wr;
    logic                        set_wr;
    logic                        clr_wr;
    logic [DW-1:0]               fsel_rd;
    logic [DW-1:0]               lev_rd;
    logic [NPINS-1:0]            is_out;
    logic [SD_COUNT-1:0][FW-1:0] sd_code;
    bus_st_t                     b_d, b_q;

    gpio_addr_dec u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign fsel_wr = wr_en && (dec.kind == RK_FSEL);
    assign set_wr  = wr_en && (dec.kind == RK_SET);
    assign clr_wr  = wr_en && (dec.kind == RK_CLR);

    gpio_fsel_bank u_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (fsel_wr),
        .idx     (dec.idx),
        .wdata   (wdata[SELW-1:0]),
        .rd_word (fsel_rd),
        .is_out  (is_out),
        .sd_code (sd_code)
    );

    gpio_level_bank u_lev (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_wr  (set_wr),
        .clr_wr  (clr_wr),
        .idx     (dec.idx),
        .wdata   (wdata),
        .is_out  (is_out),
        .rd_word (lev_rd),
        .pin_out (pin_out)
    );

    gpio_sd_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .sd_code (sd_code),
        .route   (sd_route)
    );

    always_comb begin
        b_d = b_q;
        if (rd_en) begin
            unique case (dec.kind)
                RK_FSEL: b_d.rdata = fsel_rd;
                RK_LEV:  b_d.rdata = lev_rd;
                default: b_d.rdata = '0;
            endcase
        end
        b_d.err = (rd_en || wr_en) && (dec.kind == RK_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rdata   = b_q.rdata;
    assign bus_err = b_q.err;

    // R11: no access means no error pulse
    p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |=> !bus_err);

    // R11: a refused write leaves the pins untouched
    p_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && dec.kind == RK_NONE |=> $stable(pin_out));

    // R12: read data holds without a read strobe
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R3: the last function word carries only in-range fields
    p_last_fsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && dec.kind == RK_FSEL && dec.idx == IW'(NFSEL - 1)
        |=> rdata[DW-1:LAST_BITS] == '0);

    // R6: writing a level word drives nothing new
    p_lev_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && dec.kind == RK_LEV |=> $stable(pin_out));

    // R10: placeholders read zero with no error
    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && dec.kind == RK_ZERO |=> rdata == '0 && !bus_err);

endmodule

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 34;
    // Requirements covered by the table: R2 R3 R4 R5 R6 R10 R11
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd2},
        '{1'b1, 12'h000, 32'h0,         32'h3FFF_FFFF, 1'b0, 8'd2},
        '{1'b0, 12'h004, 32'h1234_5678, 32'h0000_0000, 1'b0, 8'd2},
        '{1'b1, 12'h004, 32'h0,         32'h1234_5678, 1'b0, 8'd2},
        '{1'b0, 12'h014, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd3},
        '{1'b1, 12'h014, 32'h0,         32'h0000_0FFF, 1'b0, 8'd3},
        '{1'b1, 12'h01C, 32'h0,         32'h0000_0000, 1'b0, 8'd4},
        '{1'b1, 12'h028, 32'h0,         32'h0000_0000, 1'b0, 8'd5},
        '{1'b0, 12'h01C, 32'hA5A5_0F0F, 32'h0000_0000, 1'b0, 8'd4},
        '{1'b1, 12'h034, 32'h0,         32'hA5A5_0F0F, 1'b0, 8'd4},
        '{1'b0, 12'h01C, 32'h0000_0030, 32'h0000_0000, 1'b0, 8'd4},
        '{1'b1, 12'h034, 32'h0,         32'hA5A5_0F3F, 1'b0, 8'd4},
        '{1'b0, 12'h028, 32'h0000_000F, 32'h0000_0000, 1'b0, 8'd5},
        '{1'b1, 12'h034, 32'h0,         32'hA5A5_0F30, 1'b0, 8'd5},
        '{1'b0, 12'h020, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd4},
        '{1'b1, 12'h038, 32'h0,         32'h003F_FFFF, 1'b0, 8'd4},
        '{1'b0, 12'h02C, 32'h0020_0001, 32'h0000_0000, 1'b0, 8'd5},
        '{1'b1, 12'h038, 32'h0,         32'h001F_FFFE, 1'b0, 8'd5},
        '{1'b0, 12'h034, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'd6},
        '{1'b1, 12'h034, 32'h0,         32'hA5A5_0F30, 1'b0, 8'd6},
        '{1'b0, 12'h038, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'd6},
        '{1'b1, 12'h038, 32'h0,         32'h001F_FFFE, 1'b0, 8'd6},
        '{1'b0, 12'h040, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd10},
        '{1'b1, 12'h040, 32'h0,         32'h0000_0000, 1'b0, 8'd10},
        '{1'b1, 12'h088, 32'h0,         32'h0000_0000, 1'b0, 8'd10},
        '{1'b1, 12'h09C, 32'h0,         32'h0000_0000, 1'b0, 8'd10},
        '{1'b0, 12'h018, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 8'd11},
        '{1'b1, 12'h018, 32'h0,         32'h0000_0000, 1'b1, 8'd11},
        '{1'b0, 12'h01D, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 8'd11},
        '{1'b0, 12'h02A, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 8'd11},
        '{1'b1, 12'h034, 32'h0,         32'hA5A5_0F30, 1'b0, 8'd11},
        '{1'b0, 12'h100, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 8'd11},
        '{1'b1, 12'h000, 32'h0,         32'h3FFF_FFFF, 1'b0, 8'd11},
        '{1'b1, 12'h048, 32'h0,         32'h0000_0000, 1'b1, 8'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        bus_err;
    logic [53:0] pin_out;
    logic        sd_route;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .bus_err  (bus_err),
        .pin_out  (pin_out),
        .sd_route (sd_route)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;

        idle(3);
        // R1: state while held in reset and right after release
        chk("R1 rdata", {32'h0, rdata}, 64'h0);
        chk("R1 bus_err", {63'h0, bus_err}, 64'h0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 pin_out", {10'h0, pin_out}, 64'h0);
        chk("R1 sd_route", {63'h0, sd_route}, 64'h0);
        bus_rd(12'h000, r);
        chk("R1 fsel0", {32'h0, r}, 64'h0);
        bus_rd(12'h034, r);
        chk("R1 level0", {32'h0, r}, 64'h0);
        bus_rd(12'h038, r);
        chk("R1 level1", {32'h0, r}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
            if (VEC[v].rd) begin
                bus_rd(VEC[v].addr, r);
                chk({tag, " rdata"}, {32'h0, r}, {32'h0, VEC[v].exp});
            end else begin
                bus_wr(VEC[v].addr, VEC[v].data);
            end
            chk({tag, " err"}, {63'h0, bus_err}, {63'h0, VEC[v].err});
        end

        // R11: the error pulse lasts one cycle
        bus_wr(12'h0A0, 32'h1);
        chk("R11 err pulse", {63'h0, bus_err}, 64'h1);
        idle(1);
        chk("R11 err gone", {63'h0, bus_err}, 64'h0);

        // R7: pins 0..9 to output, show level bits 4,5,8,9
        chk("R7 not output", {54'h0, pin_out[9:0]}, 64'h0);
        bus_wr(12'h000, 32'h0924_9249);
        chk("R7 outputs on", {54'h0, pin_out[9:0]}, 64'h330);
        bus_wr(12'h01C, 32'h0000_0001);
        chk("R7 set pin0", {54'h0, pin_out[9:0]}, 64'h331);
        bus_wr(12'h000, 32'h0924_9248);
        chk("R7 pin0 off", {54'h0, pin_out[9:0]}, 64'h330);
        bus_rd(12'h034, r);
        chk("R8 level kept", {32'h0, r}, 64'hA5A5_0F31);

        // R8: pin 40 level was set while it was an input
        chk("R8 pin40 idle", {63'h0, pin_out[40]}, 64'h0);
        bus_wr(12'h010, 32'h0000_0001);
        chk("R8 pin40 out", {63'h0, pin_out[40]}, 64'h1);

        // R9: pins 50-53 are code 7, route holds A
        idle(1);
        chk("R9 mixed hold A", {63'h0, sd_route}, 64'h0);
        bus_wr(12'h010, 32'h2400_0001);
        idle(1);
        chk("R9 partial B", {63'h0, sd_route}, 64'h0);
        bus_wr(12'h014, 32'h0000_0924);
        idle(1);
        chk("R9 all four", {63'h0, sd_route}, 64'h1);
        bus_wr(12'h014, 32'h0000_0000);
        idle(1);
        chk("R9 mixed hold B", {63'h0, sd_route}, 64'h1);
        bus_wr(12'h010, 32'h0000_0001);
        idle(1);
        chk("R9 all zero", {63'h0, sd_route}, 64'h0);

        // R12: read and write together return the old value
        @(negedge clk);
        addr  = 12'h008;
        wdata = 32'h0000_0001;
        wr_en = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk("R12 old value", {32'h0, rdata}, 64'h0);
        bus_rd(12'h008, r);
        chk("R12 new value", {32'h0, r}, 64'h1);
        idle(3);
        chk("R12 hold", {32'h0, rdata}, 64'h1);

        // R1: reset mid-run clears route B, codes and levels
        bus_wr(12'h010, 32'h2400_0001);
        bus_wr(12'h014, 32'h0000_0924);
        idle(1);
        chk("R1 pre-reset route", {63'h0, sd_route}, 64'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset route", {63'h0, sd_route}, 64'h0);
        chk("R1 reset pins", {10'h0, pin_out}, 64'h0);
        chk("R1 reset rdata", {32'h0, rdata}, 64'h0);
        rst_n = 1'b1;
        bus_rd(12'h014, r);
        chk("R1 reset fsel5", {32'h0, r}, 64'h0);
        bus_rd(12'h034, r);
        chk("R1 reset level0", {32'h0, r}, 64'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule